// File: doc/BRIEF.md
# Segmented Gamma Table Write Port

This block is the programming side of a three-segment gamma table. A host writes registers through a single write strobe with an address. It sets an index, optionally with auto-increment, and then streams 32-bit data words. Each table entry needs two data words in a row. The first word holds the upper ten bits of red, green and blue, and the second holds the lower six bits. The two halves are merged into a 48-bit entry of three 16-bit channels, and the entry is stored only when the second word arrives.

The block has two index/data pairs. The superfine pair addresses a small table of its own. The main pair uses one index that runs through the fine table and then through the coarse table. Three per-channel maximum registers hold the full-scale output value. Index and maximum registers can be read back through a combinational register read port. Stored entries can be read back through a combinational lookup port that takes a segment select and an entry number.

Top module: `gamma_pal_port`

## Requirements
- R1: After reset, both index registers read 0 with auto-increment clear, and all three maximum registers read 0.
- R2: An entry is merged as channel = {first[hi], second[lo]}. The high parts come from the first word at red 29:20, green 19:10 and blue 9:0. The low parts come from the second word at red 29:24, green 19:14 and blue 9:4. On the lookup port the entry reads {red, green, blue}, with red in bits 47:32.
- R3: A single data write (the first half) changes no stored entry and does not move the index.
- R4: With auto-increment set (bit 31 of the index register), each completed entry advances that pair's index by one, and the index reads back through the register port.
- R5: With auto-increment clear, the index stays fixed, and repeated pairs of writes overwrite the same entry.
- R6: Writing an index register discards any pending first half of that pair.
- R7: The superfine index covers entries 0 to SF_N-1 and wraps from the last entry to 0. Lookup segment code 0 reads this table.
- R8: Main index value p below FINE_N stores into fine slot p+1 (segment code 1). Higher values store into coarse entry p-FINE_N (segment code 2). The index wraps to 0 after the last coarse entry. Fine slot 0 and segment code 3 read as zero.
- R9: Maximum registers at addresses 4 (red), 5 (green) and 6 (blue) each keep the low MAX_W bits of the written word.
- R10: An index value (bits 15:0) at or above the size of its pair's range loads the index as 0.
- R11: A write to an unmapped address (7) changes no register. The address map is: 0 superfine index, 1 superfine data, 2 main index, 3 main data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register address for reads |
| rd_data | output | 32 | Register read data (combinational) |
| lkp_seg | input | 2 | Lookup segment: 0 superfine, 1 fine, 2 coarse |
| lkp_idx | input | 9 | Lookup entry number |
| lkp_rgb | output | 48 | Stored entry {red, green, blue} |

## Verification
The bench uses the default sizes: 9 superfine entries, 256 fine entries, 256 coarse entries and 17-bit maximums. With these sizes a full auto-increment run of 512 main entries reaches every fine slot, crosses from fine to coarse, and wraps back to index 0. At the same sizes the 9-entry superfine wrap and the out-of-range index loads (9 and 600) can be checked against fixed numbers.

// File: rtl/gamma_pal_port.sv
module gamma_pal_port #(
  parameter int SF_N     = 9,
  parameter int FINE_N   = 256,
  parameter int COARSE_N = 256,
  parameter int MAX_W    = 17
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_addr,
  input  logic [31:0]                      wr_data,
  input  logic [2:0]                       rd_addr,
  output logic [31:0]                      rd_data,
  input  logic [1:0]                       lkp_seg,
  input  logic [$clog2(FINE_N+1)-1:0]      lkp_idx,
  output logic [47:0]                      lkp_rgb
);
  localparam int MAIN_N  = FINE_N + COARSE_N;
  localparam int SF_IW   = $clog2(SF_N);
  localparam int MAIN_IW = $clog2(MAIN_N);
  localparam int CW      = $clog2(COARSE_N);
  localparam int LKW     = $clog2(FINE_N + 1);

  localparam logic [2:0] A_SF_IDX = 3'd0, A_SF_DAT = 3'd1, A_MN_IDX = 3'd2, A_MN_DAT = 3'd3,
                         A_MAX_R  = 3'd4, A_MAX_G  = 3'd5, A_MAX_B  = 3'd6;
  localparam logic [SF_IW-1:0]   SF_LAST = SF_IW'(SF_N - 1);
  localparam logic [MAIN_IW-1:0] MN_LAST = MAIN_IW'(MAIN_N - 1);
  localparam logic [MAIN_IW-1:0] MN_FINE = MAIN_IW'(FINE_N);

  logic [SF_IW-1:0]   sf_idx;
  logic [MAIN_IW-1:0] mn_idx;
  logic               sf_ai, mn_ai, sf_ph, mn_ph;
  logic [29:0]        sf_hold, mn_hold;
  logic [MAX_W-1:0]   max_r, max_g, max_b;

  logic [47:0] sf_mem     [0:SF_N-1];
  logic [47:0] fine_mem   [1:FINE_N];
  logic [47:0] coarse_mem [0:COARSE_N-1];

  wire sf_iwr  = wr_en && wr_addr == A_SF_IDX;
  wire mn_iwr  = wr_en && wr_addr == A_MN_IDX;
  wire sf_dwr  = wr_en && wr_addr == A_SF_DAT;
  wire mn_dwr  = wr_en && wr_addr == A_MN_DAT;
  wire sf_done = sf_dwr && sf_ph;
  wire mn_done = mn_dwr && mn_ph;

  wire [15:0] raw_idx = wr_data[15:0];

  function automatic logic [47:0] merge(input logic [29:0] hi, input logic [31:0] lo);
    return {hi[29:20], lo[29:24], hi[19:10], lo[19:14], hi[9:0], lo[9:4]};
  endfunction

  wire [47:0]        sf_entry   = merge(sf_hold, wr_data);
  wire [47:0]        mn_entry   = merge(mn_hold, wr_data);
  wire               mn_coarse  = mn_idx >= MN_FINE;
  wire [MAIN_IW-1:0] coarse_off = mn_idx - MN_FINE;
  wire [MAIN_IW-1:0] fine_slot  = mn_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_idx <= '0; sf_ai <= 1'b0; sf_ph <= 1'b0; sf_hold <= '0;
      mn_idx <= '0; mn_ai <= 1'b0; mn_ph <= 1'b0; mn_hold <= '0;
      max_r  <= '0; max_g <= '0;   max_b <= '0;
    end else begin
      if (sf_iwr) begin
        sf_idx <= (raw_idx < 16'(SF_N)) ? raw_idx[SF_IW-1:0] : '0;
        sf_ai  <= wr_data[31];
        sf_ph  <= 1'b0;
      end else if (sf_dwr) begin
        sf_ph <= ~sf_ph;
        if (!sf_ph) sf_hold <= wr_data[29:0];
        else if (sf_ai) sf_idx <= (sf_idx == SF_LAST) ? '0 : sf_idx + 1'b1;
      end
      if (mn_iwr) begin
        mn_idx <= (raw_idx < 16'(MAIN_N)) ? raw_idx[MAIN_IW-1:0] : '0;
        mn_ai  <= wr_data[31];
        mn_ph  <= 1'b0;
      end else if (mn_dwr) begin
        mn_ph <= ~mn_ph;
        if (!mn_ph) mn_hold <= wr_data[29:0];
        else if (mn_ai) mn_idx <= (mn_idx == MN_LAST) ? '0 : mn_idx + 1'b1;
      end
      if (wr_en && wr_addr == A_MAX_R) max_r <= wr_data[MAX_W-1:0];
      if (wr_en && wr_addr == A_MAX_G) max_g <= wr_data[MAX_W-1:0];
      if (wr_en && wr_addr == A_MAX_B) max_b <= wr_data[MAX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (sf_done) sf_mem[sf_idx] <= sf_entry;
    if (mn_done && !mn_coarse) fine_mem[fine_slot] <= mn_entry;
    if (mn_done && mn_coarse) coarse_mem[coarse_off[CW-1:0]] <= mn_entry;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SF_IDX: begin rd_data[SF_IW-1:0] = sf_idx; rd_data[31] = sf_ai; end
      A_MN_IDX: begin rd_data[MAIN_IW-1:0] = mn_idx; rd_data[31] = mn_ai; end
      A_MAX_R:  rd_data[MAX_W-1:0] = max_r;
      A_MAX_G:  rd_data[MAX_W-1:0] = max_g;
      A_MAX_B:  rd_data[MAX_W-1:0] = max_b;
      default:  rd_data = '0;
    endcase
  end

  always_comb begin
    lkp_rgb = '0;
    case (lkp_seg)
      2'd0: if (lkp_idx < LKW'(SF_N)) lkp_rgb = sf_mem[lkp_idx[SF_IW-1:0]];
      2'd1: if (lkp_idx != '0 && lkp_idx <= LKW'(FINE_N)) lkp_rgb = fine_mem[lkp_idx];
      2'd2: if (lkp_idx < LKW'(COARSE_N)) lkp_rgb = coarse_mem[lkp_idx[CW-1:0]];
      default: lkp_rgb = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{wr_data[30], coarse_off[MAIN_IW-1:CW]};

  AST_SF_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sf_idx <= SF_LAST);  // R7
  AST_MN_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) mn_idx <= MN_LAST);  // R8
  AST_MN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mn_done && mn_ai && mn_idx != MN_LAST |=> mn_idx == $past(mn_idx) + 1'b1);  // R4
  AST_MN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    mn_done && mn_ai && mn_idx == MN_LAST |=> mn_idx == '0);  // R8
  AST_SF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sf_done && sf_ai && sf_idx == SF_LAST |=> sf_idx == '0);  // R7
  AST_FIXED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    mn_done && !mn_ai |=> $stable(mn_idx));  // R5
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mn_dwr && !mn_ph |=> $stable(mn_idx) && mn_ph);  // R3
  AST_PHASE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    mn_iwr || sf_iwr |=> !(mn_ph && $past(mn_iwr)) && !(sf_ph && $past(sf_iwr)));  // R6
endmodule

// File: tb/gamma_pal_port_bench.sv
`timescale 1ns/1ps
module gamma_pal_port_bench;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [1:0] lkp_seg = 0;
  logic [8:0] lkp_idx = 0;
  logic [47:0] lkp_rgb;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gamma_pal_port u_gamma_pal_port (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .lkp_seg, .lkp_idx, .lkp_rgb);

  logic [47:0] sf_exp [0:8];
  logic [47:0] fine_exp [1:256];
  logic [47:0] coarse_exp [0:255];

  function automatic logic [31:0] hi_word(input logic [47:0] e);
    return {2'b0, e[47:38], e[31:22], e[15:6]};
  endfunction
  function automatic logic [31:0] lo_word(input logic [47:0] e);
    return {2'b0, e[37:32], 4'b0, e[21:16], 4'b0, e[5:0], 4'b0};
  endfunction
  function automatic logic [47:0] rnd48();
    return {16'($urandom), 32'($urandom)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic put(input logic [2:0] a, input logic [47:0] e);
    wr(a, hi_word(e)); wr(a, lo_word(e));
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic lk(input logic [1:0] s, input int i, output logic [47:0] v);
    lkp_seg = s; lkp_idx = 9'(i); #1; v = lkp_rgb;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [47:0] e, got;
    int bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rdr(3'd0, v); chk("R1 sf index", v, 0);
    rdr(3'd2, v); chk("R1 main index", v, 0);
    rdr(3'd4, v); chk("R1 max red", v, 0);
    rdr(3'd5, v); chk("R1 max green", v, 0);
    rdr(3'd6, v); chk("R1 max blue", v, 0);

    // R9 maximum registers
    wr(3'd4, 32'hFFFF_FFFF); wr(3'd5, 32'h0001_0000); wr(3'd6, 32'h1234_5678);
    rdr(3'd4, v); chk("R9 max red", v, 32'h1FFFF);
    rdr(3'd5, v); chk("R9 max green", v, 32'h10000);
    rdr(3'd6, v); chk("R9 max blue", v, 32'h05678);

    // R11 unmapped address
    wr(3'd7, 32'hFFFF_FFFF);
    rdr(3'd4, v); chk("R11 max red kept", v, 32'h1FFFF);
    rdr(3'd0, v); chk("R11 sf index kept", v, 0);
    rdr(3'd2, v); chk("R11 main index kept", v, 0);

    // R2 packing, directed
    wr(3'd0, 32'h0000_0003);
    wr(3'd1, 32'h2AB_3C4D5 & 32'h3FFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    lk(2'd0, 3, got);
    e = {{32'h2AB3C4D5 >> 20}[9:0], 6'h3F, {32'h2AB3C4D5 >> 10}[9:0], 6'h3F, 10'(32'h2AB3C4D5), 6'h3F};
    chk("R2 packing all-ones low", got, e);
    e = 48'hABCD_1234_5A5A;
    put(3'd1, e);
    lk(2'd0, 3, got); chk("R2 packing pattern", got, e);

    // R7 superfine auto-increment with wrap
    wr(3'd0, 32'h8000_0000);
    for (int i = 0; i < 9; i++) begin sf_exp[i] = rnd48(); put(3'd1, sf_exp[i]); end
    rdr(3'd0, v); chk("R7 sf index wrapped", v, 32'h8000_0000);
    bad = 0;
    for (int i = 0; i < 9; i++) begin lk(2'd0, i, got); if (got !== sf_exp[i]) bad++; end
    chk("R7 sf entries", 64'(bad), 0);
    e = rnd48(); put(3'd1, e); sf_exp[0] = e;
    lk(2'd0, 0, got); chk("R7 sf rewrite at 0", got, e);
    rdr(3'd0, v); chk("R4 sf index after one", v, 32'h8000_0001);

    // R3 first half alone
    wr(3'd1, hi_word(48'hFFFF_FFFF_FFFF));
    lk(2'd0, 1, got); chk("R3 entry untouched", got, sf_exp[1]);
    rdr(3'd0, v); chk("R3 index unmoved", v, 32'h8000_0001);

    // R6 index write drops pending half
    wr(3'd0, 32'h8000_0001);
    e = 48'h0123_4567_89AB; put(3'd1, e);
    lk(2'd0, 1, got); chk("R6 pair after index write", got, e);
    rdr(3'd0, v); chk("R6 index after pair", v, 32'h8000_0002);

    // R8 main walk across fine then coarse and wrap
    wr(3'd2, 32'h8000_0000);
    for (int p = 0; p < 512; p++) begin
      e = rnd48();
      if (p < 256) fine_exp[p + 1] = e; else coarse_exp[p - 256] = e;
      put(3'd3, e);
      if (p == 100) begin rdr(3'd2, v); chk("R4 main index mid-run", v, 32'h8000_0065); end
    end
    rdr(3'd2, v); chk("R8 main index wrapped", v, 32'h8000_0000);
    bad = 0;
    for (int i = 1; i <= 256; i++) begin lk(2'd1, i, got); if (got !== fine_exp[i]) bad++; end
    chk("R8 fine slots 1..256", 64'(bad), 0);
    bad = 0;
    for (int i = 0; i < 256; i++) begin lk(2'd2, i, got); if (got !== coarse_exp[i]) bad++; end
    chk("R8 coarse entries", 64'(bad), 0);
    lk(2'd1, 0, got); chk("R8 fine slot 0 zero", got, 0);
    lk(2'd3, 5, got); chk("R8 segment 3 zero", got, 0);

    // R5 fixed index overwrites
    wr(3'd2, 32'd300);
    for (int k = 0; k < 3; k++) begin e = rnd48(); put(3'd3, e); end
    rdr(3'd2, v); chk("R5 index fixed", v, 32'd300);
    lk(2'd2, 44, got); chk("R5 last pair wins", got, e);
    lk(2'd2, 45, got); chk("R5 neighbour untouched", got, coarse_exp[45]);
    wr(3'd2, 32'd255); e = rnd48(); put(3'd3, e);
    lk(2'd1, 256, got); chk("R8 last fine slot", got, e);

    // R10 out-of-range index loads
    wr(3'd2, 32'h8000_0258);
    rdr(3'd2, v); chk("R10 main index 600", v, 32'h8000_0000);
    wr(3'd0, 32'd9);
    rdr(3'd0, v); chk("R10 sf index 9", v, 0);
    wr(3'd0, 32'd8);
    rdr(3'd0, v); chk("R10 sf index 8 kept", v, 32'd8);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule